// File: doc/BRIEF.md
# Operand Bypass and Hazard Control

This block is the pure decision logic that keeps a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback) correct without software help. Each cycle it looks at the two source register numbers of the instruction sitting in execute, and at the destination number, write enable and load flag of the two older instructions in memory and writeback. It tells the two ALU operand multiplexers, which sit right after the execute-stage operand registers, where to take each operand from. The choices are the register file copy, the ALU result held between execute and memory, or the value held between memory and writeback.

A load result is not ready in the memory stage. When the execute instruction reads the register a load in memory is about to write, the block freezes fetch, decode and execute for one cycle and sends an empty slot into memory. In the next cycle the load has reached writeback and the held instruction picks the value up through the writeback bypass. When the execute stage resolves a taken branch or jump, the block kills the two younger instructions in fetch and decode. The register file is assumed to write early and read late in a cycle, so decode-stage reads never need a bypass of their own.

The logic has no clock or storage. The one-cycle length of a load-use stall follows from the pipeline advancing the load into writeback while the empty slot fills memory.

Top module: `pipe_hazard_unit`

## Requirements
- R1: With no qualifying producer match, each operand select is 2'b00 (register file) and hold_front, bubble_m, kill_f and kill_d are all 0.
- R2: When a source equals m_rd, m_wen is 1, m_rd is non-zero and m_is_load is 0, that operand's select is 2'b01 (execute/memory ALU result).
- R3: When a source equals w_rd, w_wen is 1 and w_rd is non-zero, and no R2 match applies, that operand's select is 2'b10 (memory/writeback value).
- R4: When a source matches both the memory and the writeback producer, the memory-stage value (2'b01) is chosen.
- R5: A producer destination of register 0 never causes a bypass or a stall, even for a load.
- R6: A producer with its write enable at 0 never causes a bypass or a stall.
- R7: When a source matches a load in memory (m_is_load 1, m_wen 1, m_rd non-zero), hold_front and bubble_m are 1, and that operand never selects 2'b01; it selects 2'b10 if writeback matches, otherwise 2'b00.
- R8: In the cycle after a load-use stall, with the load in writeback and an empty slot in memory, the held operand selects 2'b10 and hold_front is 0, so the stall lasts exactly one cycle.
- R9: When x_redirect is 1, kill_f and kill_d are 1 and hold_front and bubble_m are 0, even if a load-use match is present; kill_f and kill_d are 0 otherwise.
- R10: The two operands are decided independently: each select depends only on its own source number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_rs1 | input | 5 | First source register number of the execute instruction |
| x_rs2 | input | 5 | Second source register number of the execute instruction |
| m_rd | input | 5 | Destination of the memory-stage instruction |
| m_wen | input | 1 | Memory-stage instruction writes a register |
| m_is_load | input | 1 | Memory-stage instruction is a load |
| w_rd | input | 5 | Destination of the writeback-stage instruction |
| w_wen | input | 1 | Writeback-stage instruction writes a register |
| x_redirect | input | 1 | Taken branch or jump resolved in execute |
| fwd_a_sel | output | 2 | Source select for ALU operand A |
| fwd_b_sel | output | 2 | Source select for ALU operand B |
| hold_front | output | 1 | Freeze fetch, decode and execute for this cycle |
| bubble_m | output | 1 | Send an empty slot into the memory stage |
| kill_f | output | 1 | Turn the fetch-stage instruction into a NOP |
| kill_d | output | 1 | Turn the decode-stage instruction into a NOP |

## Verification
The selects are tried with a match only in memory, only in writeback, in both, with the match on operand A only, on B only, and split across the two, which tells priority apart from per-operand independence. Matches against register 0 and against producers with write disabled show that the qualification terms are really applied. A load match is driven alone, with a writeback match behind it, and followed by the next pipeline state, which separates suppression of the memory bypass from the stall and confirms the stall ends after one cycle. A redirect is applied with and without a simultaneous load match to show the kill controls and their precedence.

// File: rtl/hz_pkg.sv
`timescale 1ns/1ps
package hz_pkg;

    // Number of register-number inputs of an ALU instruction
    localparam int HZ_NUM_SRC = 2;

    // Operand source codes seen by the datapath muxes
    typedef enum logic [1:0] {
        OPSEL_REGFILE = 2'b00,
        OPSEL_XM      = 2'b01,
        OPSEL_MW      = 2'b10
    } opsel_e;

    // Pipeline action chosen for the current cycle
    typedef enum logic [1:0] {
        ACT_FLOW     = 2'b00,
        ACT_LOADUSE  = 2'b01,
        ACT_REDIRECT = 2'b10
    } hz_act_e;

endpackage

// File: rtl/hz_src_match.sv
`timescale 1ns/1ps
module hz_src_match #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] m_rd,
    input  logic              m_wen,
    input  logic              m_is_load,
    input  logic [REG_AW-1:0] w_rd,
    input  logic              w_wen,
    output logic              hit_m_alu,
    output logic              hit_m_load,
    output logic              hit_w
);

    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic m_qual;
    logic w_qual;

    // A producer only counts if it writes and its target is not register 0
    always_comb begin
        m_qual     = m_wen && (m_rd != ZERO_REG) && (src == m_rd);
        w_qual     = w_wen && (w_rd != ZERO_REG) && (src == w_rd);
        hit_m_alu  = m_qual && !m_is_load;
        hit_m_load = m_qual &&  m_is_load;
        hit_w      = w_qual;
    end

endmodule

// File: rtl/hz_opsel_encode.sv
`timescale 1ns/1ps
module hz_opsel_encode
    import hz_pkg::*;
(
    input  logic   hit_m_alu,
    input  logic   hit_w,
    output opsel_e sel
);

    // Younger producer wins when both stages carry the register
    always_comb begin
        unique case ({hit_m_alu, hit_w})
            2'b00:   sel = OPSEL_REGFILE;
            2'b01:   sel = OPSEL_MW;
            2'b10:   sel = OPSEL_XM;
            2'b11:   sel = OPSEL_XM;
            default: sel = OPSEL_REGFILE;
        endcase
    end

endmodule

// File: rtl/hz_ctrl.sv
`timescale 1ns/1ps
module hz_ctrl
    import hz_pkg::*;
(
    input  logic loaduse,
    input  logic redirect,
    output logic hold_front,
    output logic bubble_m,
    output logic kill_f,
    output logic kill_d
);

    hz_act_e act;

    // Redirect outranks a load-use stall in the same cycle
    always_comb begin
        if (redirect)
            act = ACT_REDIRECT;
        else if (loaduse)
            act = ACT_LOADUSE;
        else
            act = ACT_FLOW;
    end

    always_comb begin
        hold_front = 1'b0;
        bubble_m   = 1'b0;
        kill_f     = 1'b0;
        kill_d     = 1'b0;
        unique case (act)
            ACT_FLOW: begin
            end
            ACT_LOADUSE: begin
                hold_front = 1'b1;
                bubble_m   = 1'b1;
            end
            ACT_REDIRECT: begin
                kill_f = 1'b1;
                kill_d = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/pipe_hazard_unit.sv
`timescale 1ns/1ps
module pipe_hazard_unit #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] x_rs1,
    input  logic [REG_AW-1:0] x_rs2,
    input  logic [REG_AW-1:0] m_rd,
    input  logic              m_wen,
    input  logic              m_is_load,
    input  logic [REG_AW-1:0] w_rd,
    input  logic              w_wen,
    input  logic              x_redirect,
    output logic [1:0]        fwd_a_sel,
    output logic [1:0]        fwd_b_sel,
    output logic              hold_front,
    output logic              bubble_m,
    output logic              kill_f,
    output logic              kill_d
);

    import hz_pkg::*;

    localparam int NSRC = HZ_NUM_SRC;

    logic [REG_AW-1:0] src_num [NSRC];
    logic [NSRC-1:0]   hit_m_alu;
    logic [NSRC-1:0]   hit_m_load;
    logic [NSRC-1:0]   hit_w;
    opsel_e            sel [NSRC];

    assign src_num[0] = x_rs1;
    assign src_num[1] = x_rs2;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        hz_src_match #(.REG_AW(REG_AW)) match_i (
            .src        (src_num[g]),
            .m_rd       (m_rd),
            .m_wen      (m_wen),
            .m_is_load  (m_is_load),
            .w_rd       (w_rd),
            .w_wen      (w_wen),
            .hit_m_alu  (hit_m_alu[g]),
            .hit_m_load (hit_m_load[g]),
            .hit_w      (hit_w[g])
        );

        hz_opsel_encode enc_i (
            .hit_m_alu (hit_m_alu[g]),
            .hit_w     (hit_w[g]),
            .sel       (sel[g])
        );
    end

    assign fwd_a_sel = sel[0];
    assign fwd_b_sel = sel[1];

    hz_ctrl ctrl_i (
        .loaduse    (|hit_m_load),
        .redirect   (x_redirect),
        .hold_front (hold_front),
        .bubble_m   (bubble_m),
        .kill_f     (kill_f),
        .kill_d     (kill_d)
    );

endmodule

// File: rtl/pipe_hazard_unit_chk.sv
`timescale 1ns/1ps
module pipe_hazard_unit_chk #(
    parameter int REG_AW = 5
) (
    input logic [REG_AW-1:0] x_rs1,
    input logic [REG_AW-1:0] x_rs2,
    input logic [REG_AW-1:0] m_rd,
    input logic              m_wen,
    input logic              m_is_load,
    input logic [REG_AW-1:0] w_rd,
    input logic              w_wen,
    input logic              x_redirect,
    input logic [1:0]        fwd_a_sel,
    input logic [1:0]        fwd_b_sel,
    input logic              hold_front,
    input logic              bubble_m,
    input logic              kill_f,
    input logic              kill_d
);

    localparam logic [REG_AW-1:0] ZR = '0;

    always_comb begin
        // R4
        if (m_wen && m_rd != ZR && !m_is_load && x_rs1 == m_rd) begin
            xm_prio_a_chk: assert (fwd_a_sel == 2'b01);
        end
        // R10
        if (m_wen && m_rd != ZR && !m_is_load && x_rs2 == m_rd) begin
            xm_prio_b_chk: assert (fwd_b_sel == 2'b01);
        end
        // R5
        if (m_rd == ZR && w_rd == ZR) begin
            zero_reg_quiet_chk: assert (fwd_a_sel == 2'b00 && fwd_b_sel == 2'b00 && !hold_front);
        end
        // R7
        if (hold_front) begin
            stall_shape_chk: assert (bubble_m && m_is_load && fwd_a_sel != 2'b01 && fwd_b_sel != 2'b01);
        end
        // R9
        if (x_redirect) begin
            redirect_kill_chk: assert (kill_f && kill_d && !hold_front && !bubble_m);
        end
        // R9
        if (!x_redirect) begin
            no_spurious_kill_chk: assert (!kill_f && !kill_d);
        end
    end

endmodule

bind pipe_hazard_unit pipe_hazard_unit_chk #(.REG_AW(REG_AW)) chk_i (
    .x_rs1      (x_rs1),
    .x_rs2      (x_rs2),
    .m_rd       (m_rd),
    .m_wen      (m_wen),
    .m_is_load  (m_is_load),
    .w_rd       (w_rd),
    .w_wen      (w_wen),
    .x_redirect (x_redirect),
    .fwd_a_sel  (fwd_a_sel),
    .fwd_b_sel  (fwd_b_sel),
    .hold_front (hold_front),
    .bubble_m   (bubble_m),
    .kill_f     (kill_f),
    .kill_d     (kill_d)
);

// File: tb/pipe_hazard_unit_tb_top.sv
`timescale 1ns/1ps
module pipe_hazard_unit_tb_top;

    logic       clk = 1'b0;
    logic [4:0] x_rs1 = '0, x_rs2 = '0, m_rd = '0, w_rd = '0;
    logic       m_wen = 1'b0, m_is_load = 1'b0, w_wen = 1'b0, x_redirect = 1'b0;
    logic [1:0] fwd_a_sel, fwd_b_sel;
    logic       hold_front, bubble_m, kill_f, kill_d;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [1:0] a;
        logic [1:0] b;
        logic       hold;
        logic       bub;
        logic       kf;
        logic       kd;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    always #10 clk = ~clk;

    pipe_hazard_unit dut_i (
        .x_rs1(x_rs1), .x_rs2(x_rs2), .m_rd(m_rd), .m_wen(m_wen),
        .m_is_load(m_is_load), .w_rd(w_rd), .w_wen(w_wen),
        .x_redirect(x_redirect), .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
        .hold_front(hold_front), .bubble_m(bubble_m), .kill_f(kill_f), .kill_d(kill_d)
    );

    // Driver: apply one pipeline snapshot at the falling edge and queue its expectation
    task automatic drive(input logic [4:0] rs1, input logic [4:0] rs2,
                         input logic [4:0] mrd, input logic mwe, input logic mld,
                         input logic [4:0] wrd, input logic wwe, input logic redir,
                         input logic [1:0] ea, input logic [1:0] eb,
                         input logic eh, input logic ebub, input logic ek,
                         input string tag);
        exp_t e;
        @(negedge clk);
        x_rs1 = rs1; x_rs2 = rs2; m_rd = mrd; m_wen = mwe; m_is_load = mld;
        w_rd = wrd; w_wen = wwe; x_redirect = redir;
        e.a = ea; e.b = eb; e.hold = eh; e.bub = ebub; e.kf = ek; e.kd = ek; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: outputs settled half a period earlier
    always @(posedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (fwd_a_sel !== e.a || fwd_b_sel !== e.b || hold_front !== e.hold ||
                bubble_m !== e.bub || kill_f !== e.kf || kill_d !== e.kd) begin
                failures++;
                $display("FAIL %s: got a=%b b=%b hold=%b bub=%b kf=%b kd=%b exp a=%b b=%b hold=%b bub=%b kf=%b kd=%b",
                         e.tag, fwd_a_sel, fwd_b_sel, hold_front, bubble_m, kill_f, kill_d,
                         e.a, e.b, e.hold, e.bub, e.kf, e.kd);
            end
        end
    end

    initial begin
        // R1 idle pipeline
        drive(5'd0, 5'd0, 5'd0, 0, 0, 5'd0, 0, 0, 2'b00, 2'b00, 0, 0, 0, "R1 idle");
        drive(5'd3, 5'd4, 5'd5, 1, 0, 5'd6, 1, 0, 2'b00, 2'b00, 0, 0, 0, "R1 no match");
        // R2 memory-stage ALU bypass
        drive(5'd5, 5'd4, 5'd5, 1, 0, 5'd6, 1, 0, 2'b01, 2'b00, 0, 0, 0, "R2 operand A");
        drive(5'd31, 5'd2, 5'd31, 1, 0, 5'd0, 0, 0, 2'b01, 2'b00, 0, 0, 0, "R2 top register");
        // R10 operand B alone, and split sources
        drive(5'd4, 5'd5, 5'd5, 1, 0, 5'd6, 1, 0, 2'b00, 2'b01, 0, 0, 0, "R10 operand B");
        drive(5'd5, 5'd6, 5'd5, 1, 0, 5'd6, 1, 0, 2'b01, 2'b10, 0, 0, 0, "R10 split");
        // R3 writeback bypass
        drive(5'd6, 5'd1, 5'd2, 1, 0, 5'd6, 1, 0, 2'b10, 2'b00, 0, 0, 0, "R3 operand A");
        // R4 both stages match
        drive(5'd7, 5'd7, 5'd7, 1, 0, 5'd7, 1, 0, 2'b01, 2'b01, 0, 0, 0, "R4 priority");
        // R5 register 0 producers, load included
        drive(5'd0, 5'd0, 5'd0, 1, 1, 5'd0, 1, 0, 2'b00, 2'b00, 0, 0, 0, "R5 x0");
        // R6 write enable low
        drive(5'd8, 5'd8, 5'd8, 0, 1, 5'd8, 0, 0, 2'b00, 2'b00, 0, 0, 0, "R6 both off");
        drive(5'd8, 5'd3, 5'd8, 0, 0, 5'd8, 1, 0, 2'b10, 2'b00, 0, 0, 0, "R6 M off");
        // R7 load-use, then R8 the following pipeline state
        drive(5'd9, 5'd1, 5'd9, 1, 1, 5'd0, 0, 0, 2'b00, 2'b00, 1, 1, 0, "R7 load-use");
        drive(5'd9, 5'd1, 5'd0, 0, 0, 5'd9, 1, 0, 2'b10, 2'b00, 0, 0, 0, "R8 after stall");
        drive(5'd2, 5'd12, 5'd12, 1, 1, 5'd12, 1, 0, 2'b00, 2'b10, 1, 1, 0, "R7 W behind load");
        // R9 redirect
        drive(5'd3, 5'd4, 5'd5, 1, 0, 5'd6, 1, 1, 2'b00, 2'b00, 0, 0, 1, "R9 redirect");
        drive(5'd9, 5'd1, 5'd9, 1, 1, 5'd0, 0, 1, 2'b00, 2'b00, 0, 0, 1, "R9 over stall");
        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            failures++;
            $display("FAIL scoreboard: got %0d pending exp 0", sb_q.size());
        end
        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule